// File: doc/BRIEF.md
# Flash Query Mode Probe Sequencer

This block brings a parallel NOR flash bank into its query mode. On a start request it drives command writes on a simple synchronous memory master port, then reads three query locations and compares them with the expected signature characters "Q", "R" and "Y". Each character is replicated across every device lane of the bus. If the signature does not match, the block works through a fixed, ordered list of five unlock sequences. It stops at the first sequence whose signature check passes. When it finishes it raises a one-cycle done pulse, and a found flag reports whether any sequence succeeded.

A separate exit request issues the writes that return the bank to array read mode. One configurable manufacturer and device identity needs an additional reset write, and the block adds it. Command offsets are device command offsets. The block scales them to bus byte addresses from the device width and the number of interleaved devices. It also builds each data word by zero-extending the command byte to the device width and copying it into every lane. Every bus cycle is held until the memory side signals ready.

Top module: `qmode_probe_seq`

## Requirements
- R1: While reset is asserted and after it is released, the write enable, read enable and done outputs are 0 and the found flag is 0 until a probe completes.
- R2: The first unlock sequence writes 0xF0 at offset 0, then 0x98 at offset 0x55.
- R3: The second unlock sequence writes 0xF0 at offset 0, then 0xFF at offset 0, then 0x98 at offset 0x55.
- R4: The third unlock sequence writes 0xF0 at offset 0, then 0x98 at offset 0x555.
- R5: The fourth unlock sequence writes 0xF0 at offset 0, 0xAA at 0x5555, 0x55 at 0x2AAA, then 0x98 at 0x5555.
- R6: The fifth unlock sequence writes 0xF0 at offset 0, 0xAA at 0x555, 0x55 at 0x2AA, then 0x98 at 0x555.
- R7: After each sequence, offsets 0x10, 0x11 and 0x12 are read in that order and compared with the replicated codes 0x51, 0x52 and 0x59. The first mismatching read ends the check, and the next sequence starts with no further reads.
- R8: The probe ends after the first sequence that passes, with found = 1. If all five sequences fail, it ends after the fifth with found = 0. The found flag changes only in the cycle that done is high.
- R9: An exit request writes 0xF0 then 0xFF, both at offset 0. When the manufacturer input equals QUIRK_MFR and the device input equals QUIRK_DEV, a third write of 0xF0 at offset 0 follows.
- R10: A write or read stays asserted, with address and data unchanged, until ready is sampled high. Write and read enables are never high together.
- R11: Done is high for exactly one cycle, the cycle after the last bus cycle of a probe or exit is accepted.
- R12: Start and exit requests that arrive while a probe or exit is in progress are ignored, and the bus sequence is unchanged.
- R13: The bus address is offset x DEV_BYTES x LANES. Each DEV_BYTES-wide lane of the data word carries the command byte zero-extended to the lane width, with lane 0 in the low bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to run the query-mode probe |
| exit_i | input | 1 | Request to run the exit sequence |
| chip_mfr_i | input | 8 | Manufacturer identity of the attached devices |
| chip_dev_i | input | 16 | Device identity of the attached devices |
| done_o | output | 1 | One-cycle pulse when a probe or exit ends |
| found_o | output | 1 | Result of the last probe: 1 if the signature was seen |
| mem_addr_o | output | ADDR_W | Bus byte address |
| mem_wdata_o | output | 8*DEV_BYTES*LANES | Write data |
| mem_we_o | output | 1 | Write cycle request |
| mem_re_o | output | 1 | Read cycle request |
| mem_rdata_i | input | 8*DEV_BYTES*LANES | Read data, sampled when ready is high |
| mem_rdy_i | input | 1 | Memory ready; completes the current cycle |

## Verification
A start or exit request is taken at the clock edge on which it is seen. The first bus cycle then appears in the next cycle. Each later bus cycle appears in the cycle after the previous one is accepted with ready, and done is due exactly one cycle after the final accepted cycle. The bench's memory model sets ready and read data at the falling edge and records each cycle it accepts, together with the cycle number. Done and found are checked against those records at falling edges, so every comparison is made against a cycle count rather than a fixed delay, under both zero-wait and varying-wait ready patterns.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int NUM_TRIES = 5;
  localparam int OFS_W     = 16;

  localparam logic [7:0] SIG_Q = 8'h51;
  localparam logic [7:0] SIG_R = 8'h52;
  localparam logic [7:0] SIG_Y = 8'h59;
  localparam logic [OFS_W-1:0] SIG_BASE = 16'h0010;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } qps_state_e;

  typedef struct packed {
    logic [7:0]       cmd;
    logic [OFS_W-1:0] ofs;
    logic             last;
  } qps_step_t;
endpackage

// File: rtl/qps_script.sv
module qps_script
  import qps_pkg::*;
(
  input  logic       exit_mode_i,
  input  logic [2:0] try_i,
  input  logic [1:0] step_i,
  input  logic       quirk_i,
  output qps_step_t  step_o
);
  always_comb begin
    step_o = '{cmd: 8'hF0, ofs: '0, last: 1'b1};
    if (exit_mode_i) begin
      unique case (step_i)
        2'd0:    step_o = '{cmd: 8'hF0, ofs: 16'h0000, last: 1'b0};
        2'd1:    step_o = '{cmd: 8'hFF, ofs: 16'h0000, last: !quirk_i};
        default: step_o = '{cmd: 8'hF0, ofs: 16'h0000, last: 1'b1};
      endcase
    end else begin
      unique case ({try_i, step_i})
        5'b000_00: step_o = '{cmd: 8'hF0, ofs: 16'h0000, last: 1'b0};
        5'b000_01: step_o = '{cmd: 8'h98, ofs: 16'h0055, last: 1'b1};
        5'b001_00: step_o = '{cmd: 8'hF0, ofs: 16'h0000, last: 1'b0};
        5'b001_01: step_o = '{cmd: 8'hFF, ofs: 16'h0000, last: 1'b0};
        5'b001_10: step_o = '{cmd: 8'h98, ofs: 16'h0055, last: 1'b1};
        5'b010_00: step_o = '{cmd: 8'hF0, ofs: 16'h0000, last: 1'b0};
        5'b010_01: step_o = '{cmd: 8'h98, ofs: 16'h0555, last: 1'b1};
        5'b011_00: step_o = '{cmd: 8'hF0, ofs: 16'h0000, last: 1'b0};
        5'b011_01: step_o = '{cmd: 8'hAA, ofs: 16'h5555, last: 1'b0};
        5'b011_10: step_o = '{cmd: 8'h55, ofs: 16'h2AAA, last: 1'b0};
        5'b011_11: step_o = '{cmd: 8'h98, ofs: 16'h5555, last: 1'b1};
        5'b100_00: step_o = '{cmd: 8'hF0, ofs: 16'h0000, last: 1'b0};
        5'b100_01: step_o = '{cmd: 8'hAA, ofs: 16'h0555, last: 1'b0};
        5'b100_10: step_o = '{cmd: 8'h55, ofs: 16'h02AA, last: 1'b0};
        5'b100_11: step_o = '{cmd: 8'h98, ofs: 16'h0555, last: 1'b1};
        default:   step_o = '{cmd: 8'hF0, ofs: 16'h0000, last: 1'b1};
      endcase
    end
  end
endmodule

// File: rtl/qps_word_build.sv
module qps_word_build
  import qps_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int DEV_BYTES = 2,
  parameter int LANES     = 2,
  localparam int DEV_W    = 8 * DEV_BYTES,
  localparam int DATA_W   = DEV_W * LANES,
  localparam int SCALE    = DEV_BYTES * LANES
) (
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [7:0]        cmd_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] word_o
);
  assign addr_o = ADDR_W'(32'(ofs_i) * SCALE);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign word_o[l*DEV_W +: DEV_W] = DEV_W'(cmd_i);
  end
endmodule

// File: rtl/qmode_probe_seq.sv
module qmode_probe_seq
  import qps_pkg::*;
#(
  parameter int          ADDR_W    = 24,
  parameter int          DEV_BYTES = 2,
  parameter int          LANES     = 2,
  parameter logic [7:0]  QUIRK_MFR = 8'h20,
  parameter logic [15:0] QUIRK_DEV = 16'h227E,
  localparam int         DATA_W    = 8 * DEV_BYTES * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              exit_i,
  input  logic [7:0]        chip_mfr_i,
  input  logic [15:0]       chip_dev_i,
  output logic              done_o,
  output logic              found_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rdy_i
);
  localparam logic [2:0] LAST_TRY = 3'(NUM_TRIES - 1);

  // reset: asserted at once, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  qps_state_e state_q, state_d;
  logic       exit_mode_q, exit_mode_d;
  logic [2:0] try_q, try_d;
  logic [1:0] step_q, step_d;
  logic [1:0] rd_q, rd_d;
  logic       found_q, found_d;
  logic       done_q, done_d;

  logic        quirk;
  qps_step_t   cur_step;
  logic [7:0]  sig_code;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_word, rd_expect;
  logic        sig_ok;

  assign quirk = (chip_mfr_i == QUIRK_MFR) && (chip_dev_i == QUIRK_DEV);

  qps_script u_script (
    .exit_mode_i (exit_mode_q),
    .try_i       (try_q),
    .step_i      (step_q),
    .quirk_i     (quirk),
    .step_o      (cur_step)
  );

  always_comb begin
    unique case (rd_q)
      2'd0:    sig_code = SIG_Q;
      2'd1:    sig_code = SIG_R;
      default: sig_code = SIG_Y;
    endcase
  end

  qps_word_build #(.ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES), .LANES(LANES)) u_wr_build (
    .ofs_i  (cur_step.ofs),
    .cmd_i  (cur_step.cmd),
    .addr_o (wr_addr),
    .word_o (wr_word)
  );

  qps_word_build #(.ADDR_W(ADDR_W), .DEV_BYTES(DEV_BYTES), .LANES(LANES)) u_rd_build (
    .ofs_i  (SIG_BASE + OFS_W'(rd_q)),
    .cmd_i  (sig_code),
    .addr_o (rd_addr),
    .word_o (rd_expect)
  );

  assign sig_ok = (mem_rdata_i == rd_expect);

  // next-state logic
  always_comb begin
    state_d     = state_q;
    exit_mode_d = exit_mode_q;
    try_d       = try_q;
    step_d      = step_q;
    rd_d        = rd_q;
    found_d     = found_q;
    done_d      = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          exit_mode_d = 1'b0;
          try_d       = '0;
          step_d      = '0;
          state_d     = ST_WRITE;
        end else if (exit_i) begin
          exit_mode_d = 1'b1;
          step_d      = '0;
          state_d     = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (mem_rdy_i) begin
          if (cur_step.last) begin
            if (exit_mode_q) begin
              state_d = ST_IDLE;
              done_d  = 1'b1;
            end else begin
              rd_d    = '0;
              state_d = ST_READ;
            end
          end else begin
            step_d = step_q + 2'd1;
          end
        end
      end
      ST_READ: begin
        if (mem_rdy_i) begin
          if (!sig_ok) begin
            if (try_q == LAST_TRY) begin
              state_d = ST_IDLE;
              found_d = 1'b0;
              done_d  = 1'b1;
            end else begin
              try_d   = try_q + 3'd1;
              step_d  = '0;
              state_d = ST_WRITE;
            end
          end else if (rd_q == 2'd2) begin
            state_d = ST_IDLE;
            found_d = 1'b1;
            done_d  = 1'b1;
          end else begin
            rd_d = rd_q + 2'd1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q     <= ST_IDLE;
      exit_mode_q <= 1'b0;
      try_q       <= '0;
      step_q      <= '0;
      rd_q        <= '0;
      found_q     <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      state_q     <= state_d;
      exit_mode_q <= exit_mode_d;
      try_q       <= try_d;
      step_q      <= step_d;
      rd_q        <= rd_d;
      found_q     <= found_d;
      done_q      <= done_d;
    end
  end

  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_re_o    = (state_q == ST_READ);
  assign mem_addr_o  = mem_we_o ? wr_addr : (mem_re_o ? rd_addr : '0);
  assign mem_wdata_o = mem_we_o ? wr_word : '0;
  assign done_o      = done_q;
  assign found_o     = found_q;
endmodule

// File: rtl/qps_checker.sv
module qps_checker #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done_o,
  input logic              found_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              mem_we_o,
  input logic              mem_re_o,
  input logic              mem_rdy_i
);
  assert_rw_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && mem_re_o));

  assert_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_o && !mem_rdy_i) |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));

  assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re_o && !mem_rdy_i) |=> (mem_re_o && $stable(mem_addr_o)));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(mem_rdy_i && (mem_we_o || mem_re_o)));

  assert_found_moves_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(found_o) |-> done_o);
endmodule

bind qmode_probe_seq qps_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_qps_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done_o      (done_o),
  .found_o     (found_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_we_o    (mem_we_o),
  .mem_re_o    (mem_re_o),
  .mem_rdy_i   (mem_rdy_i)
);

// File: tb/sim_qmode_probe_seq.sv
`timescale 1ns/1ps
module sim_qmode_probe_seq;
  localparam int ADDR_W = 24;
  localparam int DW     = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, exit_i = 1'b0;
  logic [7:0]  chip_mfr_i = 8'h01;
  logic [15:0] chip_dev_i = 16'h1234;
  logic done_o, found_o, mem_we_o, mem_re_o;
  logic [ADDR_W-1:0] mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;
  logic mem_rdy_i = 1'b0;

  always #2.5 clk = ~clk;

  qmode_probe_seq u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .exit_i(exit_i),
    .chip_mfr_i(chip_mfr_i), .chip_dev_i(chip_dev_i),
    .done_o(done_o), .found_o(found_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .mem_re_o(mem_re_o),
    .mem_rdata_i(mem_rdata_i), .mem_rdy_i(mem_rdy_i)
  );

  int checks = 0, errors = 0;

  // memory model and monitor state
  int cycle = 0, txn = 0, wcnt = 0, wmode = 0;
  int good_try = 6, mis_idx = 0, tries_seen = 0;
  int done_cnt = 0, done_cyc = 0, last_acc_cyc = 0, hold_err = 0;
  bit pend = 0, p_we = 0;
  logic [ADDR_W-1:0] p_a;
  logic [DW-1:0] p_d;
  int lg_n = 0;
  bit lg_w [64];
  logic [ADDR_W-1:0] lg_a [64];
  logic [DW-1:0] lg_d [64];

  // expected list
  int ex_n = 0;
  bit ex_w [64];
  logic [ADDR_W-1:0] ex_a [64];
  logic [DW-1:0] ex_d [64];
  int ex_r [64];

  function automatic logic [DW-1:0] rep(logic [7:0] c);
    return {8'h00, c, 8'h00, c};   // R13: two 16-bit lanes, byte zero-extended
  endfunction

  function automatic logic [7:0] sig(int i);
    return (i == 0) ? 8'h51 : (i == 1) ? 8'h52 : 8'h59;
  endfunction

  always @(negedge clk) begin
    cycle++;
    if (done_o) begin done_cnt++; done_cyc = cycle; end
    if (pend) begin
      if (!(mem_we_o == p_we && mem_re_o == !p_we && mem_addr_o == p_a &&
            (!p_we || mem_wdata_o == p_d))) hold_err++;
    end
    if (mem_we_o && mem_re_o) hold_err++;
    mem_rdy_i = 1'b0;
    pend = 0;
    if (mem_we_o || mem_re_o) begin
      if (mem_re_o) begin
        int idx;
        idx = int'(mem_addr_o >> 2) - 16;
        mem_rdata_i = rep(sig(idx));
        if (tries_seen != good_try && idx >= mis_idx) mem_rdata_i[0] = ~mem_rdata_i[0];
      end
      if (wcnt >= ((wmode != 0) ? (txn % 3) : 0)) begin
        mem_rdy_i = 1'b1;
        wcnt = 0;
        txn++;
        last_acc_cyc = cycle;
        if (lg_n < 64) begin
          lg_w[lg_n] = mem_we_o; lg_a[lg_n] = mem_addr_o; lg_d[lg_n] = mem_wdata_o;
        end
        lg_n++;
        if (mem_we_o && mem_wdata_o[7:0] == 8'h98) tries_seen++;
      end else begin
        wcnt++;
        pend = 1; p_we = mem_we_o; p_a = mem_addr_o; p_d = mem_wdata_o;
      end
    end
  end

  always @(negedge clk) begin
    if (cycle > 150000) begin
      errors++;
      $display("FAIL watchdog: cycle %0d expected below 150000", cycle);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic add_exp(bit w, int ofs, logic [7:0] c, int req);
    ex_w[ex_n] = w; ex_a[ex_n] = ADDR_W'(ofs * 4); ex_d[ex_n] = w ? rep(c) : '0;
    ex_r[ex_n] = req; ex_n++;
  endtask

  // unlock tables: R2 attempt 1, R3 attempt 2, R4 attempt 3, R5 attempt 4, R6 attempt 5
  function automatic int t_len(int a);
    case (a) 0: return 2; 1: return 3; 2: return 2; default: return 4; endcase
  endfunction
  function automatic logic [7:0] t_cmd(int a, int s);
    case (a*4+s)
      0: return 8'hF0; 1: return 8'h98;
      4: return 8'hF0; 5: return 8'hFF; 6: return 8'h98;
      8: return 8'hF0; 9: return 8'h98;
      12: return 8'hF0; 13: return 8'hAA; 14: return 8'h55; 15: return 8'h98;
      16: return 8'hF0; 17: return 8'hAA; 18: return 8'h55; default: return 8'h98;
    endcase
  endfunction
  function automatic int t_ofs(int a, int s);
    case (a*4+s)
      1: return 'h55; 6: return 'h55; 9: return 'h555;
      13: return 'h5555; 14: return 'h2AAA; 15: return 'h5555;
      17: return 'h555; 18: return 'h2AA; 19: return 'h555;
      default: return 0;
    endcase
  endfunction

  task automatic clear_run();
    lg_n = 0; txn = 0; wcnt = 0; tries_seen = 0; done_cnt = 0; hold_err = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done_cnt == 0 && n < 2000) begin @(negedge clk); n++; end
    if (done_cnt == 0) begin
      errors++;
      $display("FAIL watchdog: done not seen, actual 0 expected 1");
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic cmp_ops(string req);
    chk(lg_n == ex_n, req, "bus cycle count", lg_n, ex_n);
    for (int i = 0; i < ex_n && i < lg_n; i++) begin
      string tag;
      tag = $sformatf("R%0d/R13 op %0d", ex_r[i], i);
      chk(lg_w[i] == ex_w[i], tag, "kind", lg_w[i], ex_w[i]);
      chk(lg_a[i] == ex_a[i], tag, "addr", lg_a[i], ex_a[i]);
      if (ex_w[i]) chk(lg_d[i] == ex_d[i], tag, "data", lg_d[i], ex_d[i]);
    end
    chk(done_cnt == 1, "R11", "done pulses", done_cnt, 1);
    chk(done_cyc == last_acc_cyc + 1, "R11", "done cycle", done_cyc, last_acc_cyc + 1);
    chk(hold_err == 0, "R10", "hold/exclusive violations", hold_err, 0);
  endtask

  task automatic run_probe(int good, int mis, int wm, bit poke);
    ex_n = 0;
    for (int a = 0; a < 5; a++) begin
      for (int s = 0; s < t_len(a); s++) add_exp(1, t_ofs(a, s), t_cmd(a, s), 2 + a);
      if (a + 1 == good) begin
        for (int i = 0; i < 3; i++) add_exp(0, 'h10 + i, 8'h00, 7);
        break;
      end
      for (int i = 0; i <= mis; i++) add_exp(0, 'h10 + i, 8'h00, 7);
    end
    @(negedge clk);
    clear_run();
    good_try = good; mis_idx = mis; wmode = wm;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (4) @(negedge clk);
      start_i = 1'b1; exit_i = 1'b1;   // R12: must be ignored
      @(negedge clk);
      start_i = 1'b0; exit_i = 1'b0;
    end
    wait_done();
    cmp_ops(poke ? "R12" : "R7");
    chk(found_o == (good <= 5), "R8", "found", found_o, (good <= 5));
  endtask

  task automatic run_exit(bit quirk, bit exp_found);
    ex_n = 0;
    add_exp(1, 0, 8'hF0, 9);
    add_exp(1, 0, 8'hFF, 9);
    if (quirk) add_exp(1, 0, 8'hF0, 9);
    chip_mfr_i = quirk ? 8'h20 : 8'h20;
    chip_dev_i = quirk ? 16'h227E : 16'h227F;
    @(negedge clk);
    clear_run();
    wmode = 1;
    exit_i = 1'b1;
    @(negedge clk);
    exit_i = 1'b0;
    wait_done();
    cmp_ops("R9");
    chk(found_o == exp_found, "R8", "found kept across exit", found_o, exp_found);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!mem_we_o && !mem_re_o && !done_o && !found_o, "R1", "outputs in reset",
        {mem_we_o, mem_re_o, done_o, found_o}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!mem_we_o && !mem_re_o && !done_o && !found_o, "R1", "outputs after reset",
        {mem_we_o, mem_re_o, done_o, found_o}, 0);

    for (int wm = 0; wm < 2; wm++)
      for (int good = 1; good <= 6; good++)
        for (int mis = 0; mis < 3; mis++)
          run_probe(good, mis, wm, 1'b0);

    run_probe(3, 1, 1, 1'b1);
    run_probe(6, 2, 0, 1'b1);
    run_exit(1'b0, 1'b0);
    run_probe(2, 0, 0, 1'b0);
    run_exit(1'b1, 1'b1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule